// File: doc/BRIEF.md
# Serial Port Byte Queue Pair with Fill Status

This block holds the two byte queues that sit between a register interface and a serial shifter. One queue carries transmit bytes from software to the shifter. The other carries received bytes from the shifter back to software. Each queue has its own control word that enables it, flushes it and sets a 6-bit request threshold. A read-only status word reports how full each queue is, and how much room is left on the transmit side.

Software reaches the block through a 2-bit register address. A write to the data address pushes one byte onto the transmit queue. A read of the data address with `reg_rd` high returns the oldest received byte and removes it. The shifter side is reduced to simple ports. `tx_data`, `tx_valid` and `tx_pop` take bytes out of the transmit queue, and `rx_byte` with `rx_push` put bytes into the receive queue. Two request outputs tell an interrupt controller when the receive queue has filled up to its threshold, or when the transmit queue has drained down to its threshold.

Top module: `sio_fifo_pair`

## Requirements
- R1: After reset both queues are disabled with threshold 0 and hold no bytes. Reads of both control words return 0, the status word reads 0x10000000, and `tx_req`, `rx_req` and `tx_valid` are all low.
- R2: The register map is: address 0 is transmit control, 1 is receive control, 2 is status and 3 is data. In a control word, bit 0 is enable, bit 1 is flush and bits 13:8 are the threshold. Enable and threshold read back as written, and the flush bit always reads back as 0.
- R3: The status word carries the receive fill count in bits 5:0, the transmit fill count in bits 13:8 and the transmit free count in bits 29:24. All other bits read 0, and the free count always equals 16 minus the transmit fill count.
- R4: A write to address 3 while the transmit queue is enabled appends `reg_wdata[7:0]`. `tx_data` shows the oldest byte, and each `tx_pop` cycle removes it, so bytes leave in the order they were written.
- R5: An `rx_push` cycle while the receive queue is enabled appends `rx_byte`. A read of address 3 returns the oldest received byte in `reg_rdata[7:0]`, and when `reg_rd` is high the byte is removed at that clock edge.
- R6: Writing a control word with bit 1 set empties that queue, so its fill count is 0 in the next cycle. Enable and threshold take the written values, and a push in the same cycle is discarded.
- R7: A push to a queue that holds 16 bytes is ignored. The fill count stays 16 and the stored bytes come out unchanged.
- R8: A pop from an empty queue is ignored. The fill count stays 0, a data read returns 0x00, and the next pushed byte is the next one read.
- R9: A push to a disabled queue is dropped and its fill count does not change.
- R10: `rx_req` is high exactly when the receive queue is enabled and its fill count is at or above its threshold.
- R11: `tx_req` is high exactly when the transmit queue is enabled and its fill count is at or below its threshold.
- R12: `tx_valid` is high exactly when the transmit fill count is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Read strobe; pops the receive queue at the data address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_pop | input | 1 | Shifter takes the oldest transmit byte |
| rx_byte | input | 8 | Byte from the shifter |
| rx_push | input | 1 | Store `rx_byte` |
| tx_req | output | 1 | Transmit fill count at or below its threshold |
| rx_req | output | 1 | Receive fill count at or above its threshold |

## Verification
The bench fills the transmit queue to all 16 entries and then pushes once more. A design that accepts this extra push would overwrite the oldest byte, or would wrap its count to 0 and show a free count of 16. It pops the empty receive queue and then pushes and reads one byte. A pointer that moved on an empty pop would return a stale byte. It flushes a queue that holds bytes and checks that the flush bit reads back clear and that the very next push is the byte that comes out. It also moves the fill counts across the two thresholds while the queues are enabled, and again while they are disabled, to catch an inverted comparison, an off-by-one at equality, or a request that ignores the enable bit.

// File: rtl/sio_fifo_pkg.sv
package sio_fifo_pkg;

  // register map
  localparam logic [1:0] ADDR_TXC  = 2'd0;
  localparam logic [1:0] ADDR_RXC  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;

  // control word fields
  localparam int CTL_EN    = 0;
  localparam int CTL_FLUSH = 1;
  localparam int CTL_LVL   = 8;
  localparam int LVL_W     = 6;

  // status word field offsets
  localparam int ST_RXF  = 0;
  localparam int ST_TXF  = 8;
  localparam int ST_FREE = 24;
  localparam int ST_W    = 6;

  // pointer step with wrap for any depth
  function automatic int unsigned ptr_adv(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic int unsigned free_space(int unsigned fill, int unsigned depth);
    return depth - fill;
  endfunction

  function automatic logic fill_req_hi(logic en, int unsigned fill, int unsigned lvl);
    return en && (fill >= lvl);
  endfunction

  function automatic logic fill_req_lo(logic en, int unsigned fill, int unsigned lvl);
    return en && (fill <= lvl);
  endfunction

endpackage

// File: rtl/sio_byte_queue.sv
module sio_byte_queue
  import sio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  // named events
  logic push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && en && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= AW'(ptr_adv(int'(wp), DEPTH));
      if (pop_ok)  rp <= AW'(ptr_adv(int'(rp), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  assign dout = empty ? '0 : mem[rp];
  assign fill = cnt;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH)); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full); // R7
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> empty); // R8
  AST_OFF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && push && !pop && !flush) |=> $stable(fill)); // R9

endmodule

// File: rtl/sio_ctl_reg.sv
module sio_ctl_reg
  import sio_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             w_en,
  input  logic             w_flush,
  input  logic [LVL_W-1:0] w_lvl,
  output logic             en,
  output logic [LVL_W-1:0] lvl,
  output logic             flush_pulse,
  output logic [31:0]      rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      lvl <= '0;
    end else if (wr) begin
      en  <= w_en;
      lvl <= w_lvl;
    end
  end

  assign flush_pulse = wr && w_flush;

  always_comb begin
    rdata = '0;
    rdata[CTL_EN] = en;
    rdata[CTL_LVL +: LVL_W] = lvl;
  end

endmodule

// File: rtl/sio_fifo_pair.sv
module sio_fifo_pair
  import sio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_pop,
  input  logic [7:0]  rx_byte,
  input  logic        rx_push,
  output logic        tx_req,
  output logic        rx_req
);

  logic             txc_wr, rxc_wr, data_wr, data_rd;
  logic             tx_en, rx_en, tx_flush, rx_flush;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic [31:0]      txc_rdata, rxc_rdata, stat;
  logic [CW-1:0]    tx_fill, rx_fill;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]       rx_dout;
  logic [ST_W-1:0]  tx_free;
  logic             wdata_unused;
  logic             rx_full_unused, tx_full_unused;

  assign wdata_unused   = ^reg_wdata[31:CTL_LVL+LVL_W];
  assign rx_full_unused = rx_full;
  assign tx_full_unused = tx_full;

  // address decode
  assign txc_wr  = reg_wr && (reg_addr == ADDR_TXC);
  assign rxc_wr  = reg_wr && (reg_addr == ADDR_RXC);
  assign data_wr = reg_wr && (reg_addr == ADDR_DATA);
  assign data_rd = reg_rd && (reg_addr == ADDR_DATA);

  sio_ctl_reg u_txc (
    .clk(clk), .rst_n(rst_n), .wr(txc_wr),
    .w_en(reg_wdata[CTL_EN]), .w_flush(reg_wdata[CTL_FLUSH]),
    .w_lvl(reg_wdata[CTL_LVL +: LVL_W]),
    .en(tx_en), .lvl(tx_lvl), .flush_pulse(tx_flush), .rdata(txc_rdata)
  );

  sio_ctl_reg u_rxc (
    .clk(clk), .rst_n(rst_n), .wr(rxc_wr),
    .w_en(reg_wdata[CTL_EN]), .w_flush(reg_wdata[CTL_FLUSH]),
    .w_lvl(reg_wdata[CTL_LVL +: LVL_W]),
    .en(rx_en), .lvl(rx_lvl), .flush_pulse(rx_flush), .rdata(rxc_rdata)
  );

  sio_byte_queue #(.DEPTH(DEPTH), .DW(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .flush(tx_flush),
    .push(data_wr), .pop(tx_pop), .din(reg_wdata[7:0]),
    .dout(tx_data), .fill(tx_fill), .full(tx_full), .empty(tx_empty)
  );

  sio_byte_queue #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .flush(rx_flush),
    .push(rx_push), .pop(data_rd), .din(rx_byte),
    .dout(rx_dout), .fill(rx_fill), .full(rx_full), .empty(rx_empty)
  );

  assign tx_free = ST_W'(free_space(int'(tx_fill), DEPTH));

  always_comb begin
    stat = '0;
    stat[ST_RXF  +: ST_W] = ST_W'(rx_fill);
    stat[ST_TXF  +: ST_W] = ST_W'(tx_fill);
    stat[ST_FREE +: ST_W] = tx_free;
  end

  always_comb begin
    case (reg_addr)
      ADDR_TXC:  reg_rdata = txc_rdata;
      ADDR_RXC:  reg_rdata = rxc_rdata;
      ADDR_STAT: reg_rdata = stat;
      default:   reg_rdata = {24'h0, rx_dout};
    endcase
  end

  assign tx_valid = !tx_empty;
  assign tx_req   = fill_req_lo(tx_en, int'(tx_fill), int'(tx_lvl));
  assign rx_req   = fill_req_hi(rx_en, int'(rx_fill), int'(rx_lvl));

  AST_FREE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(stat[ST_TXF +: ST_W]) + int'(stat[ST_FREE +: ST_W])) == DEPTH); // R3
  AST_RXREQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> (rx_en && (int'(stat[ST_RXF +: ST_W]) >= int'(rx_lvl)))); // R10
  AST_TXREQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_req); // R11
  AST_TXVALID_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (stat[ST_TXF +: ST_W] != '0)); // R12
  AST_RX_EMPTY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (rx_dout == 8'h00)); // R8

endmodule

// File: tb/sim_sio_fifo_pair.sv
`timescale 1ns/1ps
module sim_sio_fifo_pair;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  tx_data, rx_byte = 8'h00;
  logic        tx_valid, tx_pop = 1'b0, rx_push = 1'b0, tx_req, rx_req;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sio_fifo_pair u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop),
    .rx_byte(rx_byte), .rx_push(rx_push), .tx_req(tx_req), .rx_req(rx_req)
  );

  // ops: 1 tx ctrl, 2 rx ctrl, 3 push tx, 4 rx in, 5 read rx, 6 take tx
  // fields: op[47:40] arg[39:24] rxfill[23:16] txfill[15:8] byte[7:0]
  localparam int NV = 12;
  localparam logic [47:0] VEC [NV] = '{
    {8'd1, 16'h0001, 8'd0, 8'd0, 8'h00},
    {8'd2, 16'h0001, 8'd0, 8'd0, 8'h00},
    {8'd3, 16'h00A1, 8'd0, 8'd1, 8'h00},
    {8'd3, 16'h00B2, 8'd0, 8'd2, 8'h00},
    {8'd3, 16'h00C3, 8'd0, 8'd3, 8'h00},
    {8'd6, 16'h0000, 8'd0, 8'd2, 8'hA1},
    {8'd4, 16'h005A, 8'd1, 8'd2, 8'h00},
    {8'd4, 16'h006B, 8'd2, 8'd2, 8'h00},
    {8'd5, 16'h0000, 8'd1, 8'd2, 8'h5A},
    {8'd6, 16'h0000, 8'd1, 8'd1, 8'hB2},
    {8'd5, 16'h0000, 8'd0, 8'd1, 8'h6B},
    {8'd6, 16'h0000, 8'd0, 8'd0, 8'hC3}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(input int rxf, input int txf);
    return (32'(16 - txf) << 24) | (32'(txf) << 8) | 32'(rxf);
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic rx_in(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic rx_read(input string tag, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = 2'd3; reg_rd = 1'b1;
    #1;
    chk(tag, {24'h0, reg_rdata[7:0]}, {24'h0, exp});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic tx_take(input string tag, input logic [7:0] exp);
    @(negedge clk);
    #1;
    chk(tag, {24'h0, tx_data}, {24'h0, exp});
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic chk_stat(input string tag, input int rxf, input int txf);
    logic [31:0] v;
    peek(2'd2, v);
    chk(tag, v, exp_stat(rxf, txf));
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_stat("R1 status after reset", 0, 0);
    peek(2'd0, v); chk("R1 tx ctrl reset", v, 32'h0);
    peek(2'd1, v); chk("R1 rx ctrl reset", v, 32'h0);
    chk("R1 requests and valid low", {29'h0, tx_req, rx_req, tx_valid}, 32'h0);

    // vector walk: R3 R4 R5 R12
    for (int i = 0; i < NV; i++) begin
      logic [7:0] op;
      op = VEC[i][47:40];
      case (op)
        8'd1: bus_wr(2'd0, 32'(VEC[i][39:24]));
        8'd2: bus_wr(2'd1, 32'(VEC[i][39:24]));
        8'd3: bus_wr(2'd3, 32'(VEC[i][39:24]));
        8'd4: rx_in(VEC[i][31:24]);
        8'd5: rx_read($sformatf("R5 vec %0d rx byte", i), VEC[i][7:0]);
        default: tx_take($sformatf("R4 vec %0d tx byte", i), VEC[i][7:0]);
      endcase
      chk_stat($sformatf("R3 vec %0d status", i), int'(VEC[i][23:16]), int'(VEC[i][15:8]));
      chk($sformatf("R12 vec %0d tx_valid", i), {31'h0, tx_valid},
          {31'h0, VEC[i][15:8] != 8'd0});
    end

    // R2 control readback, flush bit reads 0
    bus_wr(2'd0, 32'h0000_0203);
    peek(2'd0, v); chk("R2 tx ctrl readback", v, 32'h0000_0201);

    // R11 transmit request vs threshold 2
    #1; chk("R11 tx_req fill 0 lvl 2", {31'h0, tx_req}, 32'h1);
    bus_wr(2'd3, 32'h31); bus_wr(2'd3, 32'h32); bus_wr(2'd3, 32'h33);
    #1; chk("R11 tx_req fill 3 lvl 2", {31'h0, tx_req}, 32'h0);
    tx_take("R4 tx byte 31", 8'h31);
    #1; chk("R11 tx_req fill 2 lvl 2", {31'h0, tx_req}, 32'h1);

    // R6 flush with 2 bytes held
    bus_wr(2'd0, 32'h0000_0203);
    chk_stat("R6 tx flushed", 0, 0);
    peek(2'd0, v); chk("R6 flush bit clear", v, 32'h0000_0201);
    bus_wr(2'd3, 32'h42);
    #1; chk("R6 first byte after flush", {24'h0, tx_data}, 32'h42);
    bus_wr(2'd0, 32'h0000_0003);
    chk_stat("R6 tx flushed again", 0, 0);

    // R10 receive request vs threshold 2
    bus_wr(2'd1, 32'h0000_0201);
    #1; chk("R10 rx_req fill 0 lvl 2", {31'h0, rx_req}, 32'h0);
    rx_in(8'h11);
    #1; chk("R10 rx_req fill 1 lvl 2", {31'h0, rx_req}, 32'h0);
    rx_in(8'h22);
    #1; chk("R10 rx_req fill 2 lvl 2", {31'h0, rx_req}, 32'h1);
    rx_read("R5 rx byte 11", 8'h11);
    rx_read("R5 rx byte 22", 8'h22);

    // R8 pop from empty
    rx_read("R8 empty read data", 8'h00);
    chk_stat("R8 rx count stays 0", 0, 0);
    rx_in(8'h77);
    rx_read("R8 byte after empty pop", 8'h77);

    // R7 push to full
    for (int k = 0; k < 16; k++) bus_wr(2'd3, 32'(8'h80 + k));
    chk_stat("R7 tx full", 0, 16);
    bus_wr(2'd3, 32'hEE);
    chk_stat("R7 tx full after extra push", 0, 16);
    for (int k = 0; k < 16; k++) tx_take($sformatf("R7 drain %0d", k), 8'(8'h80 + k));
    chk_stat("R7 drained", 0, 0);
    #1; chk("R12 tx_valid after drain", {31'h0, tx_valid}, 32'h0);

    // R9 disabled queues drop pushes
    bus_wr(2'd1, 32'h0000_0000);
    rx_in(8'h99);
    chk_stat("R9 rx push dropped", 0, 0);
    #1; chk("R10 rx_req off when disabled", {31'h0, rx_req}, 32'h0);
    bus_wr(2'd0, 32'h0000_0200);
    bus_wr(2'd3, 32'h55);
    chk_stat("R9 tx push dropped", 0, 0);
    #1; chk("R11 tx_req off when disabled", {31'h0, tx_req}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule